// File: doc/BRIEF.md
# Greedy Cache Configuration Tuner

This block searches for a low energy-delay-product (EDP) setting of a level-one cache while a program phase runs. A setting has three fields: capacity, ways and line length. Each field is held as a 2-bit power-of-two exponent. After `start`, the block picks an initial setting and puts it on `cand_cfg_o`. It raises `meas_req_o` so that an outside agent runs the phase with that setting. It then waits for the measured EDP on a valid/ready input stream.

The search is greedy. Capacity is tuned first, then ways, then line length. A field is raised one exponent step at a time until the measured EDP becomes strictly worse than the last accepted value. A field that is already at its legal maximum is skipped without a measurement. A full pass over the three fields is one phase execution. The block runs `N_EXEC` passes. Every pass after the first starts from the best setting seen so far. At the end, the setting with the strictly lowest EDP is driven on `final_cfg_o` with a one-cycle `done_o`.

The EDP stream follows valid/ready rules. `edp_ready_o` is high only while the block waits for a result. A word moves only in a cycle where both `edp_valid_i` and `edp_ready_o` are high. The source may hold `edp_valid_i` low for any number of cycles (back-pressure from the source side). The candidate stays stable until the word is taken.

Top module: `tune_ctrl`

## Requirements
- R1: On an accepted `start`, the first candidate issued is `mru_cfg_i` when `new_win_i` is 1, and otherwise the base setting 6'h2A (8 KB, 4 ways, 64 B lines).
- R2: Setting encoding: bits [1:0] are the capacity exponent (2 KB << e), bits [3:2] are the ways exponent (1 << e ways), and bits [5:4] are the line exponent (16 B << e). Within a pass the fields are tuned capacity first, then ways, then line.
- R3: Each trial raises the current field by exactly one exponent. The field stops when the returned EDP is strictly greater than the last accepted EDP. An equal EDP is accepted and the climb continues.
- R4: The largest legal exponent is 2. A field already at 2 is passed over with no measurement, and no issued candidate ever carries a value that was raised beyond 2.
- R5: A field that has stopped keeps its best accepted value while the later fields are tuned.
- R6: Each pass begins with a measurement of its starting setting. Passes after the first start from the best stored setting. Exactly `N_EXEC` (default 3) passes run before completion.
- R7: The result is the setting whose EDP was strictly lowest among all measurements. A later equal EDP does not replace an earlier stored setting.
- R8: `done_o` is high for exactly one cycle. In that cycle `final_cfg_o` carries the result, and `meas_req_o` and `edp_ready_o` are low.
- R9: A `start` that arrives while a search is under way has no effect on the run or its result.
- R10: `meas_req_o` is a one-cycle pulse, and the cycle after it `edp_ready_o` is high. `cand_cfg_o` is stable while `edp_ready_o` is high. `edp_ready_o` drops after a transfer. `edp_valid_i` has no effect while `edp_ready_o` is low.
- R11: After reset the block is idle: `meas_req_o`, `edp_ready_o` and `done_o` are 0, and `final_cfg_o` is 6'h2A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a search when idle |
| new_win_i | input | 1 | Fresh distance window: begin from the most recent setting |
| mru_cfg_i | input | 6 | Most recently used setting |
| meas_req_o | output | 1 | Pulse: run the phase with `cand_cfg_o` |
| cand_cfg_o | output | 6 | Candidate setting under trial |
| edp_valid_i | input | 1 | EDP word valid |
| edp_ready_o | output | 1 | Block is waiting for an EDP word |
| edp_i | input | 32 | Measured EDP, unsigned |
| done_o | output | 1 | One-cycle completion strobe |
| final_cfg_o | output | 6 | Lowest-EDP setting found |

## Verification
The bench answers each request from a cost surface that rises with the distance between the candidate and a chosen target. A target above the start shows that the climb moves field by field and stops at the first worse result. A start above the target shows that each field is rejected after a single trial. Starting at the base setting, where every field is already at the maximum, shows that saturated fields are skipped without a measurement. A flat surface makes every trial a tie, which separates accepting a trial from storing it as the best. One run repeats the climb with a delayed EDP source and stray `start` pulses, to show that the result and the measurement count do not depend on response timing or on restarts.

// File: rtl/tune_pkg.sv
package tune_pkg;
  localparam int FW = 2;           // bits per exponent field
  localparam int NF = 3;           // fields: capacity, ways, line
  localparam int CW = FW * NF;     // packed setting width

  typedef logic [CW-1:0] cfg_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ISSUE,
    S_WAIT,
    S_STEP,
    S_DONE
  } tune_st_t;
endpackage

// File: rtl/tune_step.sv
// Produces the next candidate for the field under selection and flags a
// field that can no longer be raised.
module tune_step
  import tune_pkg::*;
#(
  parameter int MAX_EXP = 2,
  parameter int SW      = 2
) (
  input  cfg_t          cur_i,
  input  logic [SW-1:0] sel_i,
  output logic          at_max_o,
  output cfg_t          cand_o
);
  logic [NF-1:0] sat;
  cfg_t          bumped [NF];

  for (genvar f = 0; f < NF; f++) begin : g_field
    logic [FW-1:0] fld;
    assign fld = cur_i[f*FW +: FW];
    assign sat[f] = (fld >= FW'(MAX_EXP));
    always_comb begin
      bumped[f] = cur_i;
      bumped[f][f*FW +: FW] = fld + FW'(1);
    end
  end

  always_comb begin
    at_max_o = 1'b1;
    cand_o   = cur_i;
    for (int f = 0; f < NF; f++) begin
      if (sel_i == SW'(f)) begin
        at_max_o = sat[f];
        cand_o   = bumped[f];
      end
    end
  end
endmodule

// File: rtl/tune_best.sv
// Holds the strictly lowest EDP seen in a search and its setting.
module tune_best
  import tune_pkg::*;
#(
  parameter int EW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  cfg_t          clr_cfg_i,
  input  logic          upd_i,
  input  logic [EW-1:0] upd_edp_i,
  input  cfg_t          upd_cfg_i,
  output cfg_t          best_cfg_o
);
  logic [EW-1:0] best_edp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_edp   <= '1;
      best_cfg_o <= '0;
    end else if (clr_i) begin
      best_edp   <= '1;
      best_cfg_o <= clr_cfg_i;
    end else if (upd_i && (upd_edp_i < best_edp)) begin
      best_edp   <= upd_edp_i;
      best_cfg_o <= upd_cfg_i;
    end
  end
endmodule

// File: rtl/tune_ctrl.sv
module tune_ctrl
  import tune_pkg::*;
#(
  parameter int          EW       = 32,
  parameter int          MAX_EXP  = 2,
  parameter int          N_EXEC   = 3,
  parameter logic [5:0]  BASE_CFG = 6'h2A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          new_win_i,
  input  logic [5:0]    mru_cfg_i,
  output logic          meas_req_o,
  output logic [5:0]    cand_cfg_o,
  input  logic          edp_valid_i,
  output logic          edp_ready_o,
  input  logic [EW-1:0] edp_i,
  output logic          done_o,
  output logic [5:0]    final_cfg_o
);
  localparam int SW = $clog2(NF + 1);
  localparam int JW = $clog2(N_EXEC + 1);

  tune_st_t      st;
  cfg_t          cur, cand, init_cfg, best_cfg, step_cand;
  logic [EW-1:0] prev_edp;
  logic [SW-1:0] sel;
  logic [JW-1:0] pass_no;
  logic          base_ph, step_max, take, worse;

  assign init_cfg = new_win_i ? cfg_t'(mru_cfg_i) : cfg_t'(BASE_CFG);
  assign take     = (st == S_WAIT) && edp_valid_i;
  assign worse    = edp_i > prev_edp;

  assign meas_req_o  = (st == S_ISSUE);
  assign edp_ready_o = (st == S_WAIT);
  assign done_o      = (st == S_DONE);
  assign cand_cfg_o  = cand;

  tune_step #(.MAX_EXP(MAX_EXP), .SW(SW)) u_step (
    .cur_i    (cur),
    .sel_i    (sel),
    .at_max_o (step_max),
    .cand_o   (step_cand)
  );

  tune_best #(.EW(EW)) u_best (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      ((st == S_IDLE) && start_i),
    .clr_cfg_i  (init_cfg),
    .upd_i      (take && (base_ph || !worse)),
    .upd_edp_i  (edp_i),
    .upd_cfg_i  (cand),
    .best_cfg_o (best_cfg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cur         <= '0;
      cand        <= '0;
      prev_edp    <= '0;
      sel         <= '0;
      pass_no     <= '0;
      base_ph     <= 1'b0;
      final_cfg_o <= BASE_CFG;
    end else begin
      unique case (st)
        S_IDLE: if (start_i) begin
          cur     <= init_cfg;
          cand    <= init_cfg;
          sel     <= '0;
          pass_no <= JW'(1);
          base_ph <= 1'b1;
          st      <= S_ISSUE;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (edp_valid_i) begin
          if (base_ph) begin
            prev_edp <= edp_i;
            base_ph  <= 1'b0;
          end else if (worse) begin
            cand <= cur;
            sel  <= sel + SW'(1);
          end else begin
            cur      <= cand;
            prev_edp <= edp_i;
          end
          st <= S_STEP;
        end
        S_STEP: begin
          if (sel == SW'(NF)) begin
            if (pass_no == JW'(N_EXEC)) begin
              final_cfg_o <= best_cfg;
              st          <= S_DONE;
            end else begin
              pass_no <= pass_no + JW'(1);
              cur     <= best_cfg;
              cand    <= best_cfg;
              sel     <= '0;
              base_ph <= 1'b1;
              st      <= S_ISSUE;
            end
          end else if (step_max) begin
            sel <= sel + SW'(1);
          end else begin
            cand <= step_cand;
            st   <= S_ISSUE;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tune_ctrl_chk.sv
module tune_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       meas_req_o,
  input logic       edp_ready_o,
  input logic       edp_valid_i,
  input logic       done_o,
  input logic [5:0] cand_cfg_o
);
  // R10
  req_ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(meas_req_o && edp_ready_o));

  // R10
  req_then_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req_o |=> edp_ready_o);

  // R10
  cand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edp_ready_o |-> $stable(cand_cfg_o));

  // R10
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edp_ready_o && edp_valid_i) |=> !edp_ready_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!meas_req_o && !edp_ready_o));
endmodule

bind tune_ctrl tune_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .meas_req_o  (meas_req_o),
  .edp_ready_o (edp_ready_o),
  .edp_valid_i (edp_valid_i),
  .done_o      (done_o),
  .cand_cfg_o  (cand_cfg_o)
);

// File: tb/tune_ctrl_tb.sv
module tune_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        new_win_i = 1'b0;
  logic [5:0]  mru_cfg_i = '0;
  logic        meas_req_o;
  logic [5:0]  cand_cfg_o;
  logic        edp_valid_i = 1'b0;
  logic        edp_ready_o;
  logic [31:0] edp_i = '0;
  logic        done_o;
  logic [5:0]  final_cfg_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tune_ctrl u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .new_win_i   (new_win_i),
    .mru_cfg_i   (mru_cfg_i),
    .meas_req_o  (meas_req_o),
    .cand_cfg_o  (cand_cfg_o),
    .edp_valid_i (edp_valid_i),
    .edp_ready_o (edp_ready_o),
    .edp_i       (edp_i),
    .done_o      (done_o),
    .final_cfg_o (final_cfg_o)
  );

  // Vector: {new_win, mru[5:0], target[5:0], flat, exp_cfg[5:0], exp_meas[7:0]}
  localparam int NV = 4;
  localparam logic [27:0] VECS [NV] = '{
    {1'b1, 6'h00, 6'h26, 1'b0, 6'h26, 8'd11},  // climb toward target (R2 R3 R5)
    {1'b0, 6'h15, 6'h00, 1'b0, 6'h2A, 8'd3},   // base, all saturated (R4)
    {1'b1, 6'h00, 6'h00, 1'b1, 6'h00, 8'd21},  // flat surface, ties (R3 R7)
    {1'b1, 6'h11, 6'h00, 1'b0, 6'h11, 8'd12}   // start above target (R3 R6)
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  function automatic logic [31:0] cost(input logic [5:0] c, input logic [5:0] t, input bit flat);
    int d = 0;
    for (int f = 0; f < 3; f++) d += absd(int'(c[2*f +: 2]), int'(t[2*f +: 2]));
    return flat ? 32'd100 : 32'(100 + 10 * d);
  endfunction

  task automatic run_case(input bit nw, input logic [5:0] mru, input logic [5:0] tgt,
                          input bit flat, input logic [5:0] exp_cfg, input int exp_n,
                          input int dly, input bit poke, input string tag);
    int  n = 0;
    bit  first = 1'b1;
    logic [5:0] init = nw ? mru : 6'h2A;
    @(negedge clk);
    new_win_i = nw;
    mru_cfg_i = mru;
    start_i   = 1'b1;
    forever begin
      @(negedge clk);
      if (first) begin start_i = 1'b0; first = 1'b0; end
      if (done_o) begin
        // R7 result, R6 pass count
        check(final_cfg_o == exp_cfg, {"R7 result ", tag}, final_cfg_o, exp_cfg);
        check(n == exp_n, {"R6 measurement count ", tag}, n, exp_n);
        @(negedge clk);
        check(done_o == 1'b0, {"R8 done width ", tag}, done_o, 0);
        break;
      end
      if (meas_req_o) begin
        n++;
        if (n == 1) check(cand_cfg_o == init, {"R1 first candidate ", tag}, cand_cfg_o, init);
        repeat (dly) @(negedge clk);
        edp_i       = cost(cand_cfg_o, tgt, flat);
        edp_valid_i = 1'b1;
        if (poke && (n == 3)) begin
          start_i   = 1'b1;  // R9 stray start mid-run
          new_win_i = 1'b1;
          mru_cfg_i = 6'h3F;
        end
        while (!edp_ready_o) @(negedge clk);
        @(negedge clk);
        edp_valid_i = 1'b0;
        start_i     = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(meas_req_o == 1'b0, "R11 meas_req", meas_req_o, 0);
    check(edp_ready_o == 1'b0, "R11 edp_ready", edp_ready_o, 0);
    check(done_o == 1'b0, "R11 done", done_o, 0);
    check(final_cfg_o == 6'h2A, "R11 final_cfg", final_cfg_o, 6'h2A);

    // R10 valid while not ready is ignored
    edp_valid_i = 1'b1;
    edp_i = 32'd5;
    repeat (4) @(negedge clk);
    check(!meas_req_o && !edp_ready_o && !done_o && final_cfg_o == 6'h2A,
          "R10 idle valid ignored", final_cfg_o, 6'h2A);
    edp_valid_i = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [27:0] v = VECS[i];
      run_case(v[27], v[26:21], v[20:15], v[14], v[13:8], int'(v[7:0]), 0, 1'b0,
               $sformatf("vec%0d", i));
    end

    // R9 and R10: delayed EDP source plus stray start while busy
    run_case(1'b1, 6'h00, 6'h26, 1'b0, 6'h26, 11, 3, 1'b1, "R9 busy start");

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule